// File: doc/BRIEF.md
# Masked Parallel Priority Interrupt Controller

This block collects interrupt requests from four devices, records each as a pending bit, and gates the pending bits through a mask register that software writes. A fixed-priority encoder looks only at the unmasked pending bits. It produces a two-bit code for the winning source and raises a status flag whenever any unmasked request is waiting. A global enable flip-flop, also written by software, decides whether that status reaches the CPU as an interrupt.

When the CPU acknowledges, the controller captures a vector address and holds it for the CPU to read. The vector's upper bits are a fixed parameter and its low two bits are the winner's code, so the four vectors are consecutive. In the same cycle the winner's pending bit is cleared. Device inputs are edge-sensitive: a request line that stays high records only one event.

A small acknowledge state machine drives the interrupt line. It has three states:
- ST_IDLE: nothing is requested. It moves to ST_ARMED when the status flag and the enable are both set.
- ST_ARMED: the interrupt is driven. It moves to ST_GAP on an accepted acknowledge, and back to ST_IDLE if the status or the enable drops.
- ST_GAP: a one-cycle pause after an acknowledge. It moves to ST_ARMED if further unmasked requests remain and are enabled, otherwise to ST_IDLE.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, irq_out, status_flag and vec_addr are 0, every pending bit is clear, every mask bit is 0 (all sources blocked) and the global enable is 0.
- R2: A 0-to-1 transition on dev_req[i] sets pending bit i at the next clock edge. A request held high sets the bit only once: after an acknowledge clears it, the bit stays clear until the line falls and rises again.
- R3: Mask bit i = 1 lets pending bit i through and 0 blocks it. A blocked pending bit does not affect status_flag or irq_out, but it is kept, and it becomes visible once its mask bit is written to 1.
- R4: status_flag equals the OR of the four unmasked pending bits.
- R5: irq_out is 1 only when status_flag and the global enable (written by en_we/en_wdata) are both 1. It rises one clock edge after that condition first holds.
- R6: Source 0 has the highest priority and source 3 the lowest. Over the unmasked pending bits m, the code is x = !m0 & !m1 and y = (!m0 & m1) | (!m0 & !m2), so source 0 gives 00, source 1 gives 01, source 2 gives 10 and source 3 gives 11. An acknowledge loads vec_addr with {VEC_BASE, x, y}, with the code in the two low bits.
- R7: An accepted acknowledge (intack = 1 while irq_out = 1) clears only the winner's pending bit at that edge. vec_addr holds its value until the next accepted acknowledge.
- R8: irq_out is 0 in the cycle after an accepted acknowledge. It returns to 1 in the following cycle if unmasked, enabled requests remain.
- R9: intack while irq_out is 0 has no effect: vec_addr and the pending bits are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_req | input | N_SRC | Device request lines, rising-edge sensitive |
| mask_we | input | 1 | Write strobe for the mask register |
| mask_wdata | input | N_SRC | New mask value (1 = source allowed) |
| en_we | input | 1 | Write strobe for the global enable |
| en_wdata | input | 1 | New global enable value |
| intack | input | 1 | CPU acknowledge, one-cycle pulse |
| irq_out | output | 1 | Interrupt request to the CPU |
| status_flag | output | 1 | Any unmasked request pending |
| vec_addr | output | VEC_W | Vector address captured at acknowledge |

## Verification
The assertions assume that intack is a single-cycle pulse, and that a pending bit can only appear after its request line was high at the previous clock edge. The bench meets these assumptions by driving every input at the falling clock edge. It raises intack for exactly one cycle, and only while it has seen irq_out high, except in the test that checks an acknowledge is ignored. It also returns the request lines low between events, except in the test that checks a held request sets its bit only once.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_GAP   = 2'd2
    } ack_state_e;

endpackage

// File: rtl/irq_req_capture.sv
module irq_req_capture #(
    parameter int unsigned N_SRC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] dev_req,
    input  logic [N_SRC-1:0] clr,
    output logic [N_SRC-1:0] pend
);

    logic [N_SRC-1:0] req_q;

    for (genvar g = 0; g < N_SRC; g++) begin : g_bit
        logic rise;
        assign rise = dev_req[g] & ~req_q[g];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                req_q[g] <= 1'b0;
                pend[g]  <= 1'b0;
            end else begin
                req_q[g] <= dev_req[g];
                // a fresh edge outranks the acknowledge clear
                pend[g]  <= (pend[g] & ~clr[g]) | rise;
            end
        end
    end

endmodule

// File: rtl/irq_prio_encoder.sv
module irq_prio_encoder #(
    parameter int unsigned N_SRC  = 4,
    parameter int unsigned CODE_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic [N_SRC-1:0]  pend,
    input  logic [N_SRC-1:0]  mask,
    output logic [CODE_W-1:0] code,
    output logic [N_SRC-1:0]  win_oh,
    output logic              any
);

    logic [N_SRC-1:0] masked;
    assign masked = pend & mask;
    assign any    = |masked;

    // scan from the lowest priority upward so the lowest index wins
    always_comb begin
        code = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (masked[i]) code = CODE_W'(i);
        end
    end

    always_comb begin
        win_oh = '0;
        if (any) win_oh[code] = 1'b1;
    end

endmodule

// File: rtl/irq_ack_fsm.sv
module irq_ack_fsm
    import irq_prio_pkg::*;
#(
    parameter int unsigned CODE_W   = 2,
    parameter int unsigned VEC_W    = 8,
    parameter int unsigned VEC_BASE = 'h1C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              status,
    input  logic              enable,
    input  logic              intack,
    input  logic [CODE_W-1:0] code,
    output logic              irq_out,
    output logic              ack_take,
    output logic [VEC_W-1:0]  vec_addr
);

    localparam int unsigned BASE_W = VEC_W - CODE_W;
    localparam logic [BASE_W-1:0] BASE_BITS = BASE_W'(VEC_BASE);

    ack_state_e state, state_nxt;
    logic       req_ok;

    assign req_ok = status & enable;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:  if (req_ok) state_nxt = ST_ARMED;
            ST_ARMED: begin
                if (ack_take)     state_nxt = ST_GAP;
                else if (!req_ok) state_nxt = ST_IDLE;
            end
            ST_GAP:   state_nxt = req_ok ? ST_ARMED : ST_IDLE;
            default:  state_nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        irq_out  = (state == ST_ARMED) & req_ok;
        ack_take = irq_out & intack;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        vec_addr <= '0;
        else if (ack_take) vec_addr <= {BASE_BITS, code};
    end

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
    parameter int unsigned N_SRC    = 4,
    parameter int unsigned VEC_W    = 8,
    parameter int unsigned VEC_BASE = 'h1C
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] dev_req,
    input  logic             mask_we,
    input  logic [N_SRC-1:0] mask_wdata,
    input  logic             en_we,
    input  logic             en_wdata,
    input  logic             intack,
    output logic             irq_out,
    output logic             status_flag,
    output logic [VEC_W-1:0] vec_addr
);

    localparam int unsigned CODE_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

    logic [N_SRC-1:0]  mask_q;
    logic              ien_q;
    logic [N_SRC-1:0]  pend;
    logic [N_SRC-1:0]  win_oh;
    logic [N_SRC-1:0]  clr;
    logic [CODE_W-1:0] code;
    logic              ack_take;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            ien_q  <= 1'b0;
        end else begin
            if (mask_we) mask_q <= mask_wdata;
            if (en_we)   ien_q  <= en_wdata;
        end
    end

    assign clr = ack_take ? win_oh : '0;

    irq_req_capture #(.N_SRC(N_SRC)) cap_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .dev_req (dev_req),
        .clr     (clr),
        .pend    (pend)
    );

    irq_prio_encoder #(.N_SRC(N_SRC), .CODE_W(CODE_W)) enc_i (
        .pend    (pend),
        .mask    (mask_q),
        .code    (code),
        .win_oh  (win_oh),
        .any     (status_flag)
    );

    irq_ack_fsm #(.CODE_W(CODE_W), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)) fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .status   (status_flag),
        .enable   (ien_q),
        .intack   (intack),
        .code     (code),
        .irq_out  (irq_out),
        .ack_take (ack_take),
        .vec_addr (vec_addr)
    );

endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
    parameter int unsigned N_SRC    = 4,
    parameter int unsigned VEC_W    = 8,
    parameter int unsigned VEC_BASE = 'h1C
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_SRC-1:0] dev_req,
    input logic             intack,
    input logic             irq_out,
    input logic             status_flag,
    input logic [VEC_W-1:0] vec_addr,
    input logic             ien,
    input logic [N_SRC-1:0] pend
);

    localparam int unsigned CODE_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;
    localparam int unsigned BASE_W = VEC_W - CODE_W;
    localparam logic [BASE_W-1:0] BASE_BITS = BASE_W'(VEC_BASE);

    p_irq_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (status_flag && ien));

    p_gap_after_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out && intack) |=> !irq_out);

    p_vec_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_out && intack) |=> $stable(vec_addr));

    p_vec_base_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out && intack) |=> (vec_addr[VEC_W-1:CODE_W] == BASE_BITS));

    p_set_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pend & ~$past(pend) & ~$past(dev_req)) == '0);

endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(
    .N_SRC(N_SRC), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .dev_req     (dev_req),
    .intack      (intack),
    .irq_out     (irq_out),
    .status_flag (status_flag),
    .vec_addr    (vec_addr),
    .ien         (ien_q),
    .pend        (pend)
);

// File: tb/irq_prio_ctrl_tb_top.sv
module irq_prio_ctrl_tb_top;

    localparam int BASE = 'h1C;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] dev_req = '0;
    logic       mask_we = 1'b0;
    logic [3:0] mask_wdata = '0;
    logic       en_we = 1'b0;
    logic       en_wdata = 1'b0;
    logic       intack = 1'b0;
    logic       irq_out;
    logic       status_flag;
    logic [7:0] vec_addr;

    int         n_checks = 0;
    int         n_errors = 0;
    int         cycles = 0;
    logic [3:0] pend_model = '0;

    always #2 clk = ~clk;

    irq_prio_ctrl #(.N_SRC(4), .VEC_W(8), .VEC_BASE(BASE)) dut_i (
        .clk(clk), .rst_n(rst_n), .dev_req(dev_req),
        .mask_we(mask_we), .mask_wdata(mask_wdata),
        .en_we(en_we), .en_wdata(en_wdata), .intack(intack),
        .irq_out(irq_out), .status_flag(status_flag), .vec_addr(vec_addr)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_errors = n_errors + 1;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic int exp_code(input logic [3:0] m);
        logic x, y;
        x = !m[0] && !m[1];
        y = (!m[0] && m[1]) || (!m[0] && !m[2]);
        return {30'd0, x, y};
    endfunction

    task automatic write_mask(input logic [3:0] m);
        mask_we = 1'b1; mask_wdata = m;
        tick(1);
        mask_we = 1'b0;
    endtask

    task automatic write_en(input logic e);
        en_we = 1'b1; en_wdata = e;
        tick(1);
        en_we = 1'b0;
    endtask

    task automatic pulse_req(input logic [3:0] p);
        dev_req = p;
        tick(1);
        dev_req = '0;
        tick(2);
        pend_model = pend_model | p;
    endtask

    task automatic drain(input logic [3:0] msk);
        for (int k = 0; k < 4; k++) begin
            if ((pend_model & msk) != 0) begin
                int c;
                c = exp_code(pend_model & msk);
                check("R5 irq asserted before ack", int'(irq_out), 1);
                intack = 1'b1;
                tick(1);
                intack = 1'b0;
                check("R6 vector value", int'(vec_addr), (BASE << 2) | c);
                check("R8 irq low after ack", int'(irq_out), 0);
                pend_model = pend_model & ~(4'b1 << c);
                tick(1);
                check("R7 only winner cleared", int'(status_flag), int'((pend_model & msk) != 0));
                check("R8 irq returns if more", int'(irq_out), int'((pend_model & msk) != 0));
            end
        end
    endtask

    initial begin
        logic [7:0] vsave;
        tick(2);
        check("R1 irq after reset", int'(irq_out), 0);
        check("R1 status after reset", int'(status_flag), 0);
        check("R1 vec after reset", int'(vec_addr), 0);
        rst_n = 1'b1;
        tick(1);

        // R1: mask resets to all-blocked and enable to 0
        pulse_req(4'b1010);
        check("R1 mask blocks after reset", int'(status_flag), 0);
        check("R1 irq blocked after reset", int'(irq_out), 0);
        write_mask(4'hF);
        check("R3 blocked bits retained", int'(status_flag), 1);
        check("R1 enable off after reset", int'(irq_out), 0);
        write_en(1'b1);
        tick(1);
        drain(4'hF);
        check("R7 all drained", int'(status_flag), 0);

        // sweep every request pattern against every mask
        for (int pat = 0; pat < 16; pat++) begin
            for (int msk = 0; msk < 16; msk++) begin
                write_mask(4'(msk));
                pulse_req(4'(pat));
                check("R4 status is OR of unmasked", int'(status_flag), int'((pend_model & 4'(msk)) != 0));
                check("R5 irq follows status", int'(irq_out), int'((pend_model & 4'(msk)) != 0));
                drain(4'(msk));
                write_mask(4'hF);
                tick(1);
                check("R3 masked bits reappear", int'(status_flag), int'(pend_model != 0));
                drain(4'hF);
                check("R7 sweep drained", int'(status_flag), 0);
            end
        end

        // R2: a held request sets its bit only once
        dev_req = 4'b0010;
        tick(3);
        check("R2 edge sets bit", int'(status_flag), 1);
        pend_model = 4'b0010;
        drain(4'hF);
        tick(4);
        check("R2 held line no reset", int'(status_flag), 0);
        dev_req = '0;
        tick(1);
        pulse_req(4'b0010);
        check("R2 new edge sets again", int'(status_flag), 1);
        drain(4'hF);

        // R5 and R9: disabled interrupt, acknowledge ignored
        vsave = vec_addr;
        write_en(1'b0);
        pulse_req(4'b1100);
        check("R5 status with enable off", int'(status_flag), 1);
        check("R5 irq with enable off", int'(irq_out), 0);
        intack = 1'b1;
        tick(1);
        intack = 1'b0;
        tick(1);
        check("R9 vec unchanged", int'(vec_addr), int'(vsave));
        check("R9 pending unchanged", int'(status_flag), 1);
        write_en(1'b1);
        check("R5 irq rises one edge later", int'(irq_out), 0);
        tick(1);
        check("R5 irq after enable", int'(irq_out), 1);
        drain(4'hF);
        check("R9 both bits survived", int'(pend_model), 0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule